// File: doc/BRIEF.md
# Fixed-Coefficient RGB to YUV Pixel Converter

This block turns one RGB pixel with eight bits per channel into one Y, U, V triple with eight bits per component. Each output component is a signed dot product of the three colour channels with integer weights that carry a 13-bit fraction. The dot product is shifted right arithmetically by 13, an offset is added (16 for luma, 128 for both chroma components), and the result is clamped to 0..255.

Pixels enter and leave through valid/ready handshakes. A single output register gives a latency of one clock, and the block accepts one pixel per clock as long as the consumer keeps taking results. When the consumer stalls, the held result stays unchanged and the input side stops accepting.

Top module: `rgb2yuv_conv`

## Requirements
- R1: Y = 16 + ((2104·R + 4130·G + 802·B) >>> 13).
- R2: U = 128 + ((3598·B − 1217·R − 2382·G) >>> 13). The shift is arithmetic, so a negative sum rounds toward minus infinity (for example R=255, G=255, B=0 gives U=15).
- R3: V = 128 + ((3598·R − 3015·G − 583·B) >>> 13), with the same arithmetic shift (R=0, G=255, B=255 gives V=16).
- R4: Each component is clamped to 0..255 after the offset. For 8-bit inputs this keeps Y within 16..235 and U and V within 15..239.
- R5: A pixel accepted on a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high directly after that same edge.
- R6: While out_valid is high and out_ready is low, out_y, out_u and out_v and out_valid hold their values and in_ready is low.
- R7: in_ready is high whenever out_valid is low or out_ready is high, so back-to-back pixels flow at one per clock.
- R8: A synchronous active-high reset clears out_valid. in_ready is high after reset.
- R9: When the held result is taken (out_valid and out_ready high) and no new pixel is accepted on that edge, out_valid goes low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| out_valid | output | 1 | Converted pixel present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_y | output | 8 | Luma |
| out_u | output | 8 | Blue-difference chroma |
| out_v | output | 8 | Red-difference chroma |

## Verification
On every cycle the embedded properties check the handshake: a stalled result stays stable with in_ready low, an accepted pixel produces out_valid on the next edge, a taken result with no new pixel drains, and the luma and chroma outputs stay inside their reachable ranges. Whether the values themselves are right, including the floor behaviour of the shift on negative chroma sums and the extreme colours, can only be shown by the bench comparing each result against its own arithmetic under random stalls and a reset in mid-stream.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

    localparam int PIX_W   = 8;
    localparam int FRAC_W  = 13;
    localparam int N_CH    = 3;
    localparam int ACC_W   = PIX_W + FRAC_W + 3;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic valid;
        pix_t y;
        pix_t u;
        pix_t v;
    } yuv_reg_t;

    // Weight for output component ch (0=Y,1=U,2=V) and input channel col (0=R,1=G,2=B)
    function automatic int weight(input int ch, input int col);
        int w;
        w = 0;
        case (ch)
            0: case (col) 0: w = 2104;  1: w = 4130;  default: w = 802;   endcase
            1: case (col) 0: w = -1217; 1: w = -2382; default: w = 3598;  endcase
            default: case (col) 0: w = 3598; 1: w = -3015; default: w = -583; endcase
        endcase
        return w;
    endfunction

    function automatic int bias(input int ch);
        return (ch == 0) ? 16 : 128;
    endfunction

endpackage

// File: rtl/yuv_dot3.sv
module yuv_dot3 #(
    parameter int PW = 8,
    parameter int AW = 24,
    parameter int W0 = 0,
    parameter int W1 = 0,
    parameter int W2 = 0
) (
    input  logic [PW-1:0]        a0,
    input  logic [PW-1:0]        a1,
    input  logic [PW-1:0]        a2,
    output logic signed [AW-1:0] sum
);
    localparam logic signed [AW-1:0] K0 = AW'(W0);
    localparam logic signed [AW-1:0] K1 = AW'(W1);
    localparam logic signed [AW-1:0] K2 = AW'(W2);

    logic signed [AW-1:0] x0, x1, x2;

    always_comb begin
        x0  = AW'({1'b0, a0});
        x1  = AW'({1'b0, a1});
        x2  = AW'({1'b0, a2});
        sum = x0 * K0 + x1 * K1 + x2 * K2;
    end
endmodule

// File: rtl/yuv_shift_sat.sv
module yuv_shift_sat #(
    parameter int PW  = 8,
    parameter int AW  = 24,
    parameter int FW  = 13,
    parameter int OFS = 16
) (
    input  logic signed [AW-1:0] sum,
    output logic [PW-1:0]        res
);
    localparam logic signed [AW-1:0] K_OFS = AW'(OFS);
    localparam logic signed [AW-1:0] K_MAX = AW'((1 << PW) - 1);

    logic signed [AW-1:0] scaled;
    logic signed [AW-1:0] biased;

    always_comb begin
        scaled = sum >>> FW;
        biased = scaled + K_OFS;
        if (biased < 0)
            res = '0;
        else if (biased > K_MAX)
            res = '1;
        else
            res = biased[PW-1:0];
    end
endmodule

// File: rtl/yuv_out_stage.sv
module yuv_out_stage
    import rgb2yuv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  pix_t nxt_y,
    input  pix_t nxt_u,
    input  pix_t nxt_v,
    output logic out_valid,
    input  logic out_ready,
    output pix_t out_y,
    output pix_t out_u,
    output pix_t out_v
);
    yuv_reg_t st_d, st_q;
    logic     take_d;

    always_comb begin
        st_d   = st_q;
        take_d = in_valid && (!st_q.valid || out_ready);
        if (take_d) begin
            st_d.valid = 1'b1;
            st_d.y     = nxt_y;
            st_d.u     = nxt_u;
            st_d.v     = nxt_v;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.valid <= 1'b0;
            st_q.y     <= '0;
            st_q.u     <= '0;
            st_q.v     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = !st_q.valid || out_ready;
    assign out_valid = st_q.valid;
    assign out_y     = st_q.y;
    assign out_u     = st_q.u;
    assign out_v     = st_q.v;

    // R6: stalled result stays put
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_u) && $stable(out_v)));

    // R6: no acceptance during a stall
    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R5: accepted pixel shows up after one edge
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R9: a taken result with no new pixel drains
    a_r9_drain: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R4: reachable ranges of the clamped components
    a_r4_luma_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));

    a_r4_chroma_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_u >= 8'd15 && out_u <= 8'd239 && out_v >= 8'd15 && out_v <= 8'd239));
endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv
    import rgb2yuv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_r,
    input  logic [7:0] in_g,
    input  logic [7:0] in_b,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_y,
    output logic [7:0] out_u,
    output logic [7:0] out_v
);
    logic signed [ACC_W-1:0] acc [N_CH];
    pix_t                    comp [N_CH];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        yuv_dot3 #(
            .PW(PIX_W), .AW(ACC_W),
            .W0(weight(ch, 0)), .W1(weight(ch, 1)), .W2(weight(ch, 2))
        ) u_dot (
            .a0(in_r), .a1(in_g), .a2(in_b), .sum(acc[ch])
        );

        yuv_shift_sat #(
            .PW(PIX_W), .AW(ACC_W), .FW(FRAC_W), .OFS(bias(ch))
        ) u_sat (
            .sum(acc[ch]), .res(comp[ch])
        );
    end

    yuv_out_stage u_stage (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .nxt_y(comp[0]), .nxt_u(comp[1]), .nxt_v(comp[2]),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );
endmodule

// File: tb/rgb2yuv_conv_bench.sv
module rgb2yuv_conv_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       out_ready = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       in_ready, out_valid;
    logic [7:0] out_y, out_u, out_v;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic       m_valid = 1'b0;
    logic [7:0] m_y = '0, m_u = '0, m_v = '0;

    always #2 clk = ~clk;

    rgb2yuv_conv u_rgb2yuv_conv (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    function automatic logic [7:0] clamp8(input int x);
        if (x < 0) return 8'd0;
        if (x > 255) return 8'd255;
        return x[7:0];
    endfunction

    function automatic logic [7:0] ref_y(input int r, input int g, input int b);
        return clamp8(16 + ((2104*r + 4130*g + 802*b) >>> 13));
    endfunction
    function automatic logic [7:0] ref_u(input int r, input int g, input int b);
        return clamp8(128 + ((3598*b - 1217*r - 2382*g) >>> 13));
    endfunction
    function automatic logic [7:0] ref_v(input int r, input int g, input int b);
        return clamp8(128 + ((3598*r - 3015*g - 583*b) >>> 13));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare outputs with model (called between edges)
    task automatic compare_outputs();
        chk("R5/R8/R9 out_valid", int'(out_valid), int'(m_valid));
        if (m_valid) begin
            chk("R1 luma", int'(out_y), int'(m_y));
            chk("R2 u", int'(out_u), int'(m_u));
            chk("R3 v", int'(out_v), int'(m_v));
        end
    endtask

    // drive one cycle at negedge, update model for the coming edge
    task automatic cycle(input logic v, input logic [7:0] r, input logic [7:0] g,
                         input logic [7:0] b, input logic rdy);
        logic acc;
        @(negedge clk);
        compare_outputs();
        in_valid  = v;
        in_r = r; in_g = g; in_b = b;
        out_ready = rdy;
        #0.5;
        chk("R6/R7 in_ready", int'(in_ready), int'(!m_valid || rdy));
        acc = v && (!m_valid || rdy);
        if (acc) begin
            m_valid = 1'b1;
            m_y = ref_y(r, g, b);
            m_u = ref_u(r, g, b);
            m_v = ref_v(r, g, b);
        end else if (rdy) begin
            m_valid = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R5 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 out_valid after reset", int'(out_valid), 0);
        chk("R8 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);
        rst = 1'b0;

        // directed corners, free flow (R1..R4, R7)
        cycle(1, 8'd0,   8'd0,   8'd0,   1);
        cycle(1, 8'd255, 8'd255, 8'd255, 1);
        cycle(1, 8'd255, 8'd0,   8'd0,   1);
        cycle(1, 8'd0,   8'd255, 8'd0,   1);
        cycle(1, 8'd0,   8'd0,   8'd255, 1);
        cycle(1, 8'd255, 8'd255, 8'd0,   1);  // R2 floor: U=15
        cycle(1, 8'd0,   8'd255, 8'd255, 1);  // R3 floor: V=16
        cycle(1, 8'd1,   8'd2,   8'd3,   1);
        cycle(0, 8'd0,   8'd0,   8'd0,   1);  // R9 drain
        cycle(0, 8'd0,   8'd0,   8'd0,   1);
        chk("R2 U for R=255,G=255,B=0", int'(ref_u(255, 255, 0)), 15);
        chk("R3 V for R=0,G=255,B=255", int'(ref_v(0, 255, 255)), 16);

        // R6: stall with new pixel offered, then release
        cycle(1, 8'd10,  8'd200, 8'd30,  0);
        cycle(1, 8'd99,  8'd98,  8'd97,  0);
        cycle(1, 8'd99,  8'd98,  8'd97,  0);
        cycle(1, 8'd99,  8'd98,  8'd97,  1);
        cycle(0, 8'd0,   8'd0,   8'd0,   1);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic v, rdy;
            v   = ($urandom % 4) != 0;
            rdy = ($urandom % 3) != 0;
            cycle(v, 8'($urandom), 8'($urandom), 8'($urandom), rdy);
        end

        // R8: reset in mid-stream with a stalled result
        cycle(1, 8'd50, 8'd60, 8'd70, 0);
        cycle(1, 8'd50, 8'd60, 8'd70, 0);
        @(negedge clk);
        compare_outputs();
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R8 out_valid cleared by reset", int'(out_valid), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        m_valid = 1'b0;
        cycle(0, 8'd0, 8'd0, 8'd0, 1);
        cycle(1, 8'd128, 8'd64, 8'd32, 1);
        cycle(0, 8'd0, 8'd0, 8'd0, 1);
        @(negedge clk);
        compare_outputs();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule